// File: doc/BRIEF.md
# Slow-Rate Infrared Frame Transmit Sequencer

This block turns a stream of payload bytes into a complete slow-rate infrared link frame and hands it one byte at a time to a downstream bit encoder. A frame opens with a programmable run of preamble flags (0xFF) and a single opening flag (0xC0). The payload follows, then a 16-bit check value computed on the fly over the payload, and finally a closing flag (0xC1). Any payload or check byte that could be mistaken for a flag or for the escape marker is sent as a two-byte escape pair.

Payload bytes arrive on a valid/ready stream with a last-byte marker. During the payload phase the block passes bytes straight through, with no storage beyond the second half of an escape pair. Output bytes leave on a valid/ready handshake. The preamble length sits in a small configuration register. Its value is captured when a frame starts, so a write never disturbs the frame already in flight.

Top module: `sir_frame_tx`

## Requirements
- R1: While `rst` is high, and afterwards until a payload byte is offered, `m_valid` and `s_ready` stay low. The preamble count resets to 10.
- R2: Every frame is emitted in this order: N preamble bytes 0xFF, one 0xC0, the escaped payload, the escaped check low byte, the escaped check high byte, one 0xC1. The 0xC1 is always the last byte.
- R3: N is the value last written through `cfg_xbof_we`/`cfg_xbof_data` before the frame's first payload byte was offered. N = 0 sends no preamble. A write during a frame changes only later frames.
- R4: The check value is a CRC over the unescaped payload: bit-reflected, polynomial 0x8408, seed 0xFFFF. Its ones' complement is sent low byte first. The payload "123456789" gives the check bytes 0x6E then 0x90.
- R5: A payload byte equal to 0xC0, 0xC1 or 0x7D is sent as 0x7D followed by the byte XOR 0x20. All other payload bytes are sent unchanged.
- R6: The same escape rule as R5 applies to both check bytes.
- R7: `s_ready` is low while a preamble, opening, check, closing or escape-second byte is offered. A new frame's bytes are not taken until the closing flag of the current frame has been accepted.
- R8: Once `m_valid` is high with `m_ready` low, `m_valid` stays high and `m_data` stays unchanged on the next cycle.
- R9: With any pattern of gaps on `s_valid` and stalls on `m_ready`, no byte is lost, duplicated or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cfg_xbof_we | input | 1 | Write strobe for the preamble count register |
| cfg_xbof_data | input | CNT_W | New preamble count |
| s_data | input | 8 | Payload byte |
| s_valid | input | 1 | Payload byte offered |
| s_last | input | 1 | Marks the final payload byte of a frame |
| s_ready | output | 1 | Payload byte accepted this cycle when high with `s_valid` |
| m_data | output | 8 | Byte offered to the bit encoder |
| m_valid | output | 1 | `m_data` is valid |
| m_ready | input | 1 | Encoder accepts `m_data` |

## Verification
The output hold property assumes that the payload source follows the usual stream rule. Once `s_valid` is raised, it stays high and `s_data`/`s_last` stay unchanged until the byte is taken, because in the payload phase `m_data` is derived directly from `s_data`. The bench's driver only raises `s_valid` on a gap-pattern bit. It then holds the byte until it sees a handshake, and changes its inputs one time unit after the rising edge. Every frame is kept non-empty and ends with `s_last`, which the sequencer depends on to reach the check phase.

// File: rtl/sir_tx_pkg.sv
package sir_tx_pkg;

    localparam int BYTE_W = 8;
    localparam int FCS_W  = 16;

    localparam logic [BYTE_W-1:0] PREAMBLE_BYTE = 8'hFF;
    localparam logic [BYTE_W-1:0] OPEN_BYTE     = 8'hC0;
    localparam logic [BYTE_W-1:0] CLOSE_BYTE    = 8'hC1;
    localparam logic [BYTE_W-1:0] ESC_BYTE      = 8'h7D;
    localparam logic [BYTE_W-1:0] ESC_FLIP      = 8'h20;

    localparam logic [FCS_W-1:0] FCS_POLY = 16'h8408;
    localparam logic [FCS_W-1:0] FCS_SEED = 16'hFFFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_OPEN,
        ST_PAYLOAD,
        ST_CHK_LO,
        ST_CHK_HI,
        ST_CLOSE
    } tx_state_e;

    typedef struct packed {
        logic              pend;
        logic [BYTE_W-1:0] data;
    } esc_slot_t;

    function automatic logic needs_escape(input logic [BYTE_W-1:0] b);
        return (b == OPEN_BYTE) || (b == CLOSE_BYTE) || (b == ESC_BYTE);
    endfunction

    function automatic logic [FCS_W-1:0] fcs_step(input logic [FCS_W-1:0] cur,
                                                  input logic [BYTE_W-1:0] b);
        logic [FCS_W-1:0] acc;
        acc = cur ^ {{(FCS_W-BYTE_W){1'b0}}, b};
        for (int i = 0; i < BYTE_W; i++) begin
            if (acc[0]) acc = (acc >> 1) ^ FCS_POLY;
            else        acc = acc >> 1;
        end
        return acc;
    endfunction

endpackage

// File: rtl/sir_xbof_reg.sv
module sir_xbof_reg #(
    parameter int CNT_W     = 8,
    parameter int RESET_CNT = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(RESET_CNT);

    always_ff @(posedge clk) begin
        if (rst)        count <= RST_VAL;
        else if (wr_en) count <= wr_data;
    end
endmodule

// File: rtl/sir_fcs_acc.sv
module sir_fcs_acc
    import sir_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic              update,
    input  logic [BYTE_W-1:0] data,
    output logic [FCS_W-1:0]  fcs
);
    always_ff @(posedge clk) begin
        if (rst || init) fcs <= FCS_SEED;
        else if (update) fcs <= fcs_step(fcs, data);
    end
endmodule

// File: rtl/sir_byte_stuffer.sv
module sir_byte_stuffer
    import sir_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] raw_byte,
    input  logic              raw_valid,
    output logic              raw_ready,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              pend,
    output logic              byte_done
);
    esc_slot_t slot;
    logic      raw_special;
    logic      raw_take;

    assign raw_special = needs_escape(raw_byte);
    assign pend        = slot.pend;
    assign raw_ready   = out_ready && !slot.pend;
    assign raw_take    = raw_valid && raw_ready;

    always_comb begin
        if (slot.pend) begin
            out_byte  = slot.data;
            out_valid = 1'b1;
        end else begin
            out_byte  = raw_special ? ESC_BYTE : raw_byte;
            out_valid = raw_valid;
        end
    end

    assign byte_done = out_valid && out_ready && (slot.pend || !raw_special);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
        end else if (slot.pend) begin
            if (out_ready) slot.pend <= 1'b0;
        end else if (raw_take && raw_special) begin
            slot.pend <= 1'b1;
            slot.data <= raw_byte ^ ESC_FLIP;
        end
    end

    // R5/R6: an escape marker taken for a special byte is always followed by a non-special second byte
    assert_escape_pair_R5: assert property (@(posedge clk) disable iff (rst)
        (raw_take && raw_special) |=> (pend && out_valid && !needs_escape(out_byte)));

    // R6: the second byte of a pair is never replaced before it is accepted
    assert_pair_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (pend && !out_ready) |=> (pend && $stable(out_byte)));
endmodule

// File: rtl/sir_frame_tx.sv
module sir_frame_tx
    import sir_tx_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int RESET_CNT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_xbof_we,
    input  logic [CNT_W-1:0]  cfg_xbof_data,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_valid,
    input  logic              s_last,
    output logic              s_ready,
    output logic [BYTE_W-1:0] m_data,
    output logic              m_valid,
    input  logic              m_ready
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tx_state_e         state;
    logic [CNT_W-1:0]  xbof_cfg;
    logic [CNT_W-1:0]  xbof_left;
    logic              last_q;

    logic [FCS_W-1:0]  fcs;
    logic [FCS_W-1:0]  fcs_inv;
    logic              stuff_active;
    logic [BYTE_W-1:0] raw_byte;
    logic              raw_valid;
    logic              raw_ready;
    logic [BYTE_W-1:0] st_byte;
    logic              st_valid;
    logic              st_pend;
    logic              st_done;
    logic              pay_take;
    logic              last_now;

    sir_xbof_reg #(.CNT_W(CNT_W), .RESET_CNT(RESET_CNT)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_xbof_we),
        .wr_data (cfg_xbof_data),
        .count   (xbof_cfg)
    );

    assign pay_take = (state == ST_PAYLOAD) && s_valid && raw_ready;

    sir_fcs_acc u_fcs (
        .clk    (clk),
        .rst    (rst),
        .init   (state == ST_IDLE),
        .update (pay_take),
        .data   (s_data),
        .fcs    (fcs)
    );

    assign fcs_inv      = ~fcs;
    assign stuff_active = (state == ST_PAYLOAD) || (state == ST_CHK_LO) || (state == ST_CHK_HI);

    always_comb begin
        unique case (state)
            ST_PAYLOAD: begin raw_byte = s_data;                  raw_valid = s_valid; end
            ST_CHK_LO:  begin raw_byte = fcs_inv[BYTE_W-1:0];     raw_valid = 1'b1;    end
            ST_CHK_HI:  begin raw_byte = fcs_inv[FCS_W-1:BYTE_W]; raw_valid = 1'b1;    end
            default:    begin raw_byte = '0;                      raw_valid = 1'b0;    end
        endcase
    end

    sir_byte_stuffer u_stuff (
        .clk       (clk),
        .rst       (rst),
        .raw_byte  (raw_byte),
        .raw_valid (raw_valid),
        .raw_ready (raw_ready),
        .out_byte  (st_byte),
        .out_valid (st_valid),
        .out_ready (m_ready && stuff_active),
        .pend      (st_pend),
        .byte_done (st_done)
    );

    always_comb begin
        unique case (state)
            ST_PREAMBLE: begin m_data = PREAMBLE_BYTE; m_valid = 1'b1; end
            ST_OPEN:     begin m_data = OPEN_BYTE;     m_valid = 1'b1; end
            ST_CLOSE:    begin m_data = CLOSE_BYTE;    m_valid = 1'b1; end
            ST_PAYLOAD, ST_CHK_LO, ST_CHK_HI:
                         begin m_data = st_byte;       m_valid = st_valid; end
            default:     begin m_data = '0;            m_valid = 1'b0; end
        endcase
    end

    assign s_ready  = (state == ST_PAYLOAD) && raw_ready;
    assign last_now = st_pend ? last_q : s_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            xbof_left <= '0;
            last_q    <= 1'b0;
        end else begin
            if (pay_take) last_q <= s_last;
            unique case (state)
                ST_IDLE: begin
                    if (s_valid) begin
                        xbof_left <= xbof_cfg;
                        state     <= (xbof_cfg == '0) ? ST_OPEN : ST_PREAMBLE;
                    end
                end
                ST_PREAMBLE: begin
                    if (m_ready) begin
                        xbof_left <= xbof_left - ONE;
                        if (xbof_left == ONE) state <= ST_OPEN;
                    end
                end
                ST_OPEN:    if (m_ready) state <= ST_PAYLOAD;
                ST_PAYLOAD: if (st_done && last_now) state <= ST_CHK_LO;
                ST_CHK_LO:  if (st_done) state <= ST_CHK_HI;
                ST_CHK_HI:  if (st_done) state <= ST_CLOSE;
                ST_CLOSE:   if (m_ready) state <= ST_IDLE;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    // R8: an offered byte is held until the encoder takes it
    assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

    // R7: no payload is taken while flags are offered
    assert_no_take_on_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PREAMBLE || state == ST_OPEN || state == ST_CLOSE) |-> !s_ready);

    // R2: after the closing flag is accepted nothing is offered on the next cycle
    assert_close_ends_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CLOSE && m_ready) |=> !m_valid);

    // R4: the check value no longer moves once the check phase starts
    assert_fcs_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHK_LO || state == ST_CHK_HI) |=> $stable(fcs));

    // R3: the preamble phase is never entered with an exhausted count
    assert_preamble_count_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PREAMBLE) |-> (xbof_left != '0));
endmodule

// File: tb/sir_frame_tx_tb_top.sv
module sir_frame_tx_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_xbof_we;
    logic [7:0] cfg_xbof_data;
    logic [7:0] s_data;
    logic       s_valid;
    logic       s_last;
    logic       s_ready;
    logic [7:0] m_data;
    logic       m_valid;
    logic       m_ready;

    always #5 clk = ~clk;

    sir_frame_tx dut_i (
        .clk           (clk),
        .rst           (rst),
        .cfg_xbof_we   (cfg_xbof_we),
        .cfg_xbof_data (cfg_xbof_data),
        .s_data        (s_data),
        .s_valid       (s_valid),
        .s_last        (s_last),
        .s_ready       (s_ready),
        .m_data        (m_data),
        .m_valid       (m_valid),
        .m_ready       (m_ready)
    );

    typedef struct packed {
        logic [7:0]  xb;
        logic [4:0]  n;
        logic [7:0]  rdy;
        logic [7:0]  val;
        logic [63:0] pay;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{8'd10, 5'd3, 8'hFF,        8'hFF,        64'h0000000000030201},
        '{8'd2,  5'd4, 8'b10110110,  8'b11011101,  64'h00000000207DC1C0},
        '{8'd0,  5'd1, 8'h5A,        8'hFF,        64'h000000000000007E},
        '{8'd1,  5'd8, 8'b01110111,  8'b10101011,  64'hC27C7DAA55C000FF},
        '{8'd3,  5'd2, 8'hFF,        8'h0F,        64'h0000000000002211}
    };

    int checks   = 0;
    int failures = 0;
    int cur_xb   = 10;

    logic [7:0] pay   [0:15];
    logic [7:0] exp_b [0:127];
    logic       no_rdy[0:127];
    int         exp_len;
    logic [7:0] rxb   [0:127];
    int         rx_n;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [15:0] ref_fcs(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        logic        fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[0] ^ b[i];
            r  = {1'b0, r[15:1]};
            if (fb) r = r ^ 16'h8408;
        end
        return r;
    endfunction

    function automatic bit is_flaglike(input logic [7:0] b);
        return (b == 8'hC0) || (b == 8'hC1) || (b == 8'h7D);
    endfunction

    task automatic push(input logic [7:0] v, input logic g);
        exp_b[exp_len]  = v;
        no_rdy[exp_len] = g;
        exp_len++;
    endtask

    task automatic push_esc(input logic [7:0] v, input logic g);
        if (is_flaglike(v)) begin
            push(8'h7D, g);
            push(v ^ 8'h20, 1'b1);
        end else begin
            push(v, g);
        end
    endtask

    task automatic build_expected(input int n, input int xb);
        logic [15:0] c;
        exp_len = 0;
        for (int i = 0; i < xb; i++) push(8'hFF, 1'b1);
        push(8'hC0, 1'b1);
        c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            c = ref_fcs(c, pay[i]);
            push_esc(pay[i], 1'b0);
        end
        c = ~c;
        push_esc(c[7:0], 1'b1);
        push_esc(c[15:8], 1'b1);
        push(8'hC1, 1'b1);
    endtask

    task automatic write_cfg(input int v);
        cfg_xbof_we   = 1'b1;
        cfg_xbof_data = v[7:0];
        @(posedge clk); #1;
        cfg_xbof_we   = 1'b0;
        cur_xb        = v;
    endtask

    task automatic run_frame(input int n, input logic [7:0] rdy_pat,
                             input logic [7:0] val_pat, input int mid_wr,
                             input string req);
        int src_i, cyc, mism, first_bad, gate_v, hold_v;
        bit done, hs_in, hs_out, prev_hold;
        logic [7:0] prev_data;
        build_expected(n, cur_xb);
        src_i = 0; cyc = 0; done = 0; gate_v = 0; hold_v = 0;
        prev_hold = 0; prev_data = '0; hs_in = 0; rx_n = 0;
        while (!done && cyc < 3000) begin
            cfg_xbof_we = 1'b0;
            if (hs_in) begin
                src_i++;
                s_valid = 1'b0;
            end
            if (!s_valid && src_i < n && val_pat[cyc % 8]) begin
                s_valid = 1'b1;
                s_data  = pay[src_i];
                s_last  = (src_i == n - 1);
            end
            m_ready = rdy_pat[cyc % 8];
            if (cyc == 3 && mid_wr >= 0) begin
                cfg_xbof_we   = 1'b1;
                cfg_xbof_data = mid_wr[7:0];
            end
            @(negedge clk);
            if (prev_hold && (!m_valid || m_data != prev_data)) hold_v++;
            prev_hold = m_valid && !m_ready;
            prev_data = m_data;
            if (m_valid && rx_n < exp_len && no_rdy[rx_n] && s_ready) gate_v++;
            hs_in  = s_valid && s_ready;
            hs_out = m_valid && m_ready;
            if (hs_out && rx_n < 128) begin
                rxb[rx_n] = m_data;
                rx_n++;
                if (m_data == 8'hC1) done = 1;
            end
            @(posedge clk); #1;
            cyc++;
        end
        cfg_xbof_we = 1'b0;
        s_valid     = 1'b0;
        m_ready     = 1'b0;
        if (mid_wr >= 0) cur_xb = mid_wr;
        check(done, req, "closing flag seen", int'(done), 1);
        check(rx_n == exp_len, req, "frame length", rx_n, exp_len);
        mism = 0; first_bad = -1;
        for (int i = 0; i < rx_n && i < exp_len; i++) begin
            if (rxb[i] != exp_b[i]) begin
                if (first_bad < 0) first_bad = i;
                mism++;
            end
        end
        if (first_bad < 0) check(mism == 0, req, "byte content", 0, 0);
        else check(1'b0, req, $sformatf("byte %0d", first_bad),
                   int'(rxb[first_bad]), int'(exp_b[first_bad]));
        check(gate_v == 0, "R7", "s_ready high outside payload slot", gate_v, 0);
        check(hold_v == 0, "R8", "output changed under stall", hold_v, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] c;
        bit found;
        int fj, fk;
        rst = 1'b1; cfg_xbof_we = 1'b0; cfg_xbof_data = '0;
        s_data = 8'h55; s_valid = 1'b1; s_last = 1'b0; m_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: quiet outputs during reset even with a byte offered
        check(m_valid == 1'b0, "R1", "m_valid in reset", int'(m_valid), 0);
        check(s_ready == 1'b0, "R1", "s_ready in reset", int'(s_ready), 0);
        @(posedge clk); #1;
        s_valid = 1'b0; rst = 1'b0;
        @(negedge clk);
        check(m_valid == 1'b0, "R1", "m_valid after reset", int'(m_valid), 0);
        check(s_ready == 1'b0, "R1", "s_ready after reset", int'(s_ready), 0);
        @(posedge clk); #1;

        // Table walk: R1 (default count on first frame), R2, R5, R9
        for (int v = 0; v < NVEC; v++) begin
            for (int i = 0; i < 8; i++) pay[i] = VECS[v].pay[8*i +: 8];
            if (int'(VECS[v].xb) != cur_xb) write_cfg(int'(VECS[v].xb));
            run_frame(int'(VECS[v].n), VECS[v].rdy, VECS[v].val, -1,
                      (v == 0) ? "R1 R2" : "R2 R5 R9");
            repeat (2) @(posedge clk); #1;
        end

        // R4: known check value for the ASCII digits 1..9, no preamble
        write_cfg(0);
        for (int i = 0; i < 9; i++) pay[i] = 8'h31 + 8'(i);
        run_frame(9, 8'hFF, 8'hFF, -1, "R4");
        check(rxb[10] == 8'h6E, "R4", "check low byte", int'(rxb[10]), 'h6E);
        check(rxb[11] == 8'h90, "R4", "check high byte", int'(rxb[11]), 'h90);

        // R3: write during a frame applies only to the following frame
        write_cfg(2);
        pay[0] = 8'hA5; pay[1] = 8'h5A;
        run_frame(2, 8'hFF, 8'hFF, 5, "R3");
        check(rxb[2] == 8'hC0, "R3", "opening flag after 2 preamble", int'(rxb[2]), 'hC0);
        pay[0] = 8'h01;
        run_frame(1, 8'hFF, 8'hFF, -1, "R3");
        check(rxb[5] == 8'hC0 && rxb[4] == 8'hFF, "R3", "opening flag after 5 preamble",
              int'(rxb[5]), 'hC0);

        // R6: search for a two-byte payload whose check bytes need escaping
        found = 0; fj = 0; fk = 0;
        for (int j = 0; j < 256 && !found; j++) begin
            for (int k = 0; k < 256 && !found; k++) begin
                c = ~ref_fcs(ref_fcs(16'hFFFF, 8'(j)), 8'(k));
                if (is_flaglike(c[7:0]) || is_flaglike(c[15:8])) begin
                    found = 1; fj = j; fk = k;
                end
            end
        end
        check(found, "R6", "escape-needing check found", int'(found), 1);
        write_cfg(1);
        pay[0] = 8'(fj); pay[1] = 8'(fk);
        run_frame(2, 8'b11010111, 8'hFF, -1, "R6");

        // R7: back-to-back frames, next payload offered immediately
        pay[0] = 8'h7D; pay[1] = 8'h10; pay[2] = 8'hC1;
        run_frame(3, 8'b11101101, 8'hFF, -1, "R7 R5");
        run_frame(3, 8'hFF, 8'hFF, -1, "R7 R9");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule